// File: doc/BRIEF.md
# Two-Bit Serial Register Slave

This block is the slave end of a narrow register-access link. A master reaches a small local register bank through it over two serial data wires in each direction, plus a request line and an acknowledge line. The master holds request high for the whole transaction. The first request cycle carries the operation flag together with the lowest address bit. The remaining sixteen address bits follow two per cycle.

On a write, the master then shifts in the data word one bit pair per cycle. The slave answers with a one-cycle acknowledge pulse. On a read, the slave waits a fixed access latency. It then raises acknowledge and shifts the stored word out, one pair per cycle, for as many cycles as the word has bit pairs.

Request falling before the end of a transaction aborts it, and no register changes. After a completed transaction the slave ignores request until request has gone low. The word width (8, 16 or 32 bits), the register count and the read latency are parameters. Cycle 0 of a transaction is the command cycle. NP is DATA_W/2, the number of data cycles.

Top module: `ser2_reg_slave`

## Requirements
- R1: After reset, ack and dout are 0 and every register reads as zero.
- R2: In the command cycle, din[0] is the operation flag (1 = write, 0 = read) and din[1] is address bit A0.
- R3: In cycles 1 to 8, din carries the address pairs {A2,A1} up to {A16,A15}, with the lower address bit on din[0].
- R4: On a write, cycles 9 to 8+NP carry the data pairs. The lowest pair {D1,D0} comes first and the lower bit is on din[0].
- R5: A write is acknowledged by ack high for exactly one cycle, in cycle 9+NP, the cycle after the last data pair.
- R6: On a read, ack stays low for RD_LAT cycles after the last address cycle. It is then high from cycle 9+RD_LAT for NP cycles, with dout carrying {D1,D0} first, lower bit on dout[0].
- R7: ack falls after the NP-th read-data cycle, and dout is 00 in every cycle where ack is low.
- R8: If req falls before the transaction completes, the slave returns to idle without acknowledging and without changing any register.
- R9: An address at or above DEPTH reads as all zeros. A write to such an address changes no register but is still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request from master, high for the whole transaction |
| din | input | 2 | Serial bit pair from master |
| ack | output | 1 | Write-done pulse or read-data-valid window |
| dout | output | 2 | Serial read-data bit pair to master |

## Verification
The embedded properties check the following on every cycle:
- the command cycle is decoded into the address state with A0 taken from din[1];
- a write acknowledge never lasts more than one cycle;
- a request that drops mid-transaction sends the slave back to idle with ack low;
- ack stays up through a read burst;
- dout stays quiet whenever ack is low.

Some behaviour only the bench scenarios can show, because it needs whole transactions:
- the bit ordering of address and data pairs;
- the exact cycle where acknowledge rises after the read latency;
- that aborted and out-of-range writes leave stored values untouched;
- that out-of-range reads return zeros.

// File: rtl/ser2_reg_slave.sv
module ser2_reg_slave #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int RD_LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [1:0] din,
  output logic       ack,
  output logic [1:0] dout
);
  localparam int NP = DATA_W / 2;
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DATA_W + RD_LAT) + 1;
  localparam int AW = 17;
  localparam logic [CW-1:0] LASTP = CW'(NP - 1);
  localparam logic [CW-1:0] LASTA = CW'(7);
  localparam logic [CW-1:0] LASTW = CW'(RD_LAT - 1);

  typedef enum logic [2:0] {IDLE, ADDR, WDATA, WACK, WAIT, RDATA, HOLD} st_t;

  st_t               state;
  logic              wr;
  logic [AW-1:0]     addr;
  logic [CW-1:0]     cnt;
  logic [DATA_W-3:0] wsh;
  logic [DATA_W-1:0] rsh;
  logic [DATA_W-1:0] mem [DEPTH];

  wire          hit = addr < AW'(DEPTH);
  wire [IW-1:0] idx = addr[IW-1:0];

  assign ack  = (state == WACK) || (state == RDATA);
  assign dout = (state == RDATA) ? rsh[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      wr    <= 1'b0;
      addr  <= '0;
      cnt   <= '0;
      wsh   <= '0;
      rsh   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      case (state)
        IDLE: if (req) begin
          wr    <= din[0];
          addr  <= {{(AW-1){1'b0}}, din[1]};
          cnt   <= '0;
          state <= ADDR;
        end
        ADDR: if (!req) state <= IDLE;
        else begin
          addr[2*int'(cnt)+1 +: 2] <= din;
          if (cnt == LASTA) begin
            cnt   <= '0;
            state <= wr ? WDATA : WAIT;
          end else cnt <= cnt + 1'b1;
        end
        WDATA: if (!req) state <= IDLE;
        else begin
          wsh <= {din, wsh[DATA_W-3:2]};
          if (cnt == LASTP) begin
            if (hit) mem[idx] <= {din, wsh};
            state <= WACK;
          end else cnt <= cnt + 1'b1;
        end
        WACK: state <= HOLD;
        WAIT: if (!req) state <= IDLE;
        else if (cnt == LASTW) begin
          rsh   <= hit ? mem[idx] : '0;
          cnt   <= '0;
          state <= RDATA;
        end else cnt <= cnt + 1'b1;
        RDATA: if (!req) state <= IDLE;
        else begin
          rsh <= rsh >> 2;
          if (cnt == LASTP) state <= HOLD;
          else cnt <= cnt + 1'b1;
        end
        HOLD: if (!req) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  // R2
  cmd_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE && req) |=> (state == ADDR && addr[0] == $past(din[1])));

  // R5
  wack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WACK) |=> !ack);

  // R6
  rd_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RDATA && req && cnt != LASTP) |=> ack);

  // R7
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> dout == 2'b00);

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ADDR || state == WDATA || state == WAIT || state == RDATA) && !req)
    |=> (state == IDLE && !ack));
endmodule

// File: tb/ser2_reg_slave_test.sv
module ser2_reg_slave_test;
  localparam int DW  = 32;
  localparam int NP  = DW / 2;
  localparam int LAT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [1:0] din = 2'b00;
  logic       ack;
  logic [1:0] dout;

  int total = 0;
  int bad = 0;

  typedef struct { bit is_wr; logic [DW-1:0] data; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  ser2_reg_slave #(.DATA_W(DW), .DEPTH(16), .RD_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .din(din), .ack(ack), .dout(dout));

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_hdr(input bit w, input logic [16:0] a);
    @(negedge clk);
    req = 1'b1;
    din = {a[0], w};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      din = {a[2*i+2], a[2*i+1]};
    end
  endtask

  task automatic do_write(input logic [16:0] a, input logic [DW-1:0] d, input string tag);
    item_t it;
    it.is_wr = 1'b1; it.data = '0; it.tag = tag;
    q.push_back(it);
    send_hdr(1'b1, a);
    for (int i = 0; i < NP; i++) begin
      @(negedge clk);
      chk(ack == 1'b0, {tag, " R5 no early ack"}, DW'(ack), 0);
      din = d[2*i +: 2];
    end
    @(negedge clk);
    chk(ack == 1'b1, {tag, " R5 ack after last pair"}, DW'(ack), 1);
    req = 1'b0;
    din = 2'b00;
    @(negedge clk);
    chk(ack == 1'b0, {tag, " R5 single-cycle ack"}, DW'(ack), 0);
  endtask

  task automatic do_read(input logic [16:0] a, input logic [DW-1:0] exp, input string tag);
    item_t it;
    it.is_wr = 1'b0; it.data = exp; it.tag = tag;
    q.push_back(it);
    send_hdr(1'b0, a);
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      din = 2'b00;
      chk(ack == 1'b0 && dout == 2'b00, {tag, " R6 latency ack low"}, DW'(ack), 0);
    end
    repeat (NP) @(negedge clk);
    @(negedge clk);
    chk(ack == 1'b0 && dout == 2'b00, {tag, " R7 ack falls after burst"}, DW'({ack, dout}), 0);
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic abort_write(input logic [16:0] a, input logic [DW-1:0] d, input int pairs, input string tag);
    send_hdr(1'b1, a);
    for (int i = 0; i < pairs; i++) begin
      @(negedge clk);
      din = d[2*i +: 2];
    end
    @(negedge clk);
    req = 1'b0;
    din = 2'b00;
    repeat (3) begin
      @(negedge clk);
      chk(ack == 1'b0, {tag, " R8 no ack after abort"}, DW'(ack), 0);
    end
  endtask

  // monitor: pops expected items as acknowledges appear
  initial begin
    item_t it;
    logic [DW-1:0] w;
    forever begin
      @(negedge clk);
      if (rst_n && ack) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7 unexpected ack", 1, 0);
        end else begin
          it = q.pop_front();
          if (!it.is_wr) begin
            w = '0;
            w[1:0] = dout;
            for (int k = 1; k < NP; k++) begin
              @(negedge clk);
              chk(ack == 1'b1, {it.tag, " R6 ack held in burst"}, DW'(ack), 1);
              w[2*k +: 2] = dout;
            end
            chk(w == it.data, {it.tag, " read data"}, w, it.data);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ack == 1'b0 && dout == 2'b00, "R1 reset outputs", DW'({ack, dout}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(17'd0, 32'h0, "R1 reset reg0");
    do_read(17'd15, 32'h0, "R1 reset reg15");
    do_write(17'd0, 32'hA5A5_0F0F, "R4 w0");
    do_write(17'd1, 32'h1234_5678, "R2 w1");
    do_write(17'd10, 32'hDEAD_BEEF, "R3 w10");
    do_write(17'd6, 32'h8000_0001, "R3 w6");
    do_read(17'd0, 32'hA5A5_0F0F, "R4 r0");
    do_read(17'd1, 32'h1234_5678, "R2 r1");
    do_read(17'd10, 32'hDEAD_BEEF, "R3 r10");
    do_read(17'd6, 32'h8000_0001, "R6 r6");
    abort_write(17'd1, 32'hFFFF_FFFF, 5, "R8 mid-data");
    abort_write(17'd0, 32'hFFFF_FFFF, 0, "R8 end-of-addr");
    do_read(17'd1, 32'h1234_5678, "R8 r1 kept");
    do_read(17'd0, 32'hA5A5_0F0F, "R8 r0 kept");
    do_write(17'h10006, 32'h5555_AAAA, "R9 oor write");
    do_write(17'd16, 32'h0BAD_F00D, "R9 oor write16");
    do_read(17'd6, 32'h8000_0001, "R9 r6 untouched");
    do_read(17'h1000A, 32'h0, "R9 oor read");
    do_read(17'd16, 32'h0, "R9 oor read16");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R7 all items seen", DW'(q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule